// File: doc/BRIEF.md
# Ring Signal Validator

The validator decides whether activity on a telephone line is a genuine ringing signal. It watches two comparator strobes, one pulsed when the line passes the positive ring threshold and one pulsed when it passes the negative threshold. A crossing counts toward frequency measurement only when its polarity differs from the previous one. The number of timebase ticks between such alternating crossings must stay inside a programmable window for a programmable span before the frequency is accepted. Voltage steps, dial pulses and line tests therefore do not qualify.

Once the frequency is accepted, the block stops measuring it and looks for the ring to end. The ring has ended when no crossing of either polarity arrives for a programmable quiet time. A second timer, the indication delay, starts at acceptance and races that quiet timer. The envelope status goes high only if the delay finishes first, so a distinctive cadence with short bursts can be filtered or allowed.

The envelope drives an interrupt flag, which is cleared by a write-one strobe. The flag's pin has selectable polarity. A ring-detect pin can show either the validated envelope or a raw one-shot that is retriggered by every crossing. With validation disabled, the envelope follows that raw one-shot.

Top module: `ring_qualifier`

## Requirements
- R1: After reset, with validation enabled, env_o, irq_flag_o and rdet_pin_o are 0, and irq_pin_o is at its inactive level.
- R2: Only a crossing whose polarity differs from the previous one ends a frequency interval. A repeated crossing of the same threshold neither restarts the interval nor fails it.
- R3: An alternating interval shorter than ivl_min ticks returns the validator to idle and discards the partial qualification time. An interval of exactly ivl_min ticks passes.
- R4: An interval exceeding ivl_max ticks returns the validator to idle. An interval of exactly ivl_max ticks passes.
- R5: The frequency is accepted only after (qual_sel+1)*64 ticks of continuous in-tolerance activity, counted from the crossing that left idle.
- R6: At acceptance a delay of dly_sel*128 ticks starts. env_o rises when that delay completes before the quiet timeout. When the quiet timeout completes first, or in the same tick, env_o stays 0 and the validator returns to idle.
- R7: After acceptance, env_o falls once (quiet_sel+1)*32 ticks pass with no crossing of either polarity. The count restarts at every crossing.
- R8: irq_flag_o sets on a rising edge of env_o and is cleared by irq_clr. With irq_both at 0, a falling edge has no effect. A set in the same cycle as a clear wins.
- R9: With irq_both at 1, irq_flag_o also sets on a falling edge of env_o.
- R10: irq_pin_o equals irq_flag_o when irq_act_hi is 1 and its inverse when irq_act_hi is 0.
- R11: With rd_raw_sel at 0, rdet_pin_o shows the validated envelope. With rd_raw_sel at 1, it shows the raw one-shot.
- R12: Any crossing loads the one-shot for OS_TICKS ticks (default 5000). A later crossing reloads it.
- R13: With val_en at 0, the validator is held idle and env_o follows the raw one-shot.
- R14: All timers advance only in cycles where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe, one per millisecond |
| pos_cross | input | 1 | Positive-threshold crossing strobe |
| neg_cross | input | 1 | Negative-threshold crossing strobe |
| val_en | input | 1 | Validation enable |
| ivl_min | input | 6 | Shortest accepted interval in ticks |
| ivl_max | input | 6 | Longest accepted interval in ticks |
| qual_sel | input | 3 | Qualification span code |
| dly_sel | input | 3 | Indication delay code |
| quiet_sel | input | 4 | End-of-ring quiet time code |
| irq_both | input | 1 | Set the flag on both envelope edges |
| irq_act_hi | input | 1 | Interrupt pin polarity, 1 = active high |
| rd_raw_sel | input | 1 | Ring-detect pin source, 1 = raw one-shot |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| env_o | output | 1 | Ring envelope status |
| irq_flag_o | output | 1 | Interrupt flag |
| irq_pin_o | output | 1 | Interrupt pin |
| rdet_pin_o | output | 1 | Ring-detect pin |

## Verification
The indication delay and the quiet timeout can both complete on the same tick. This tie is provoked by making the last crossing coincide with acceptance and choosing a delay of 128 ticks against a quiet time of 128 ticks. The required result is that env_o stays low. Neighbouring rows move the quiet time by one code step in each direction, so the delay wins in one row and the quiet timeout wins in the other, and the envelope is judged a few ticks after the shared deadline. The interval limits are also probed exactly at ivl_min and one past ivl_max. In that second case the too-slow detection and an alternating crossing fall on the same cycle, and the validator must still reject.

// File: rtl/ring_qualifier.sv
module ring_qualifier #(
  parameter int FW       = 6,
  parameter int DW       = 3,
  parameter int EW       = 4,
  parameter int DUR_STEP = 64,
  parameter int END_STEP = 32,
  parameter int DLY_STEP = 128,
  parameter int OS_TICKS = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pos_cross,
  input  logic          neg_cross,
  input  logic          val_en,
  input  logic [FW-1:0] ivl_min,
  input  logic [FW-1:0] ivl_max,
  input  logic [DW-1:0] qual_sel,
  input  logic [DW-1:0] dly_sel,
  input  logic [EW-1:0] quiet_sel,
  input  logic          irq_both,
  input  logic          irq_act_hi,
  input  logic          rd_raw_sel,
  input  logic          irq_clr,
  output logic          env_o,
  output logic          irq_flag_o,
  output logic          irq_pin_o,
  output logic          rdet_pin_o
);

  localparam int TW  = $clog2((1 << DW) * DUR_STEP + (1 << EW) * END_STEP + (1 << DW) * DLY_STEP + 2);
  localparam int OSW = $clog2(OS_TICKS + 1);
  localparam int IW  = FW + 1;

  typedef enum logic [1:0] {S_IDLE, S_QUAL, S_WATCH, S_RING} st_t;

  st_t           st;
  logic          last_pos;
  logic [IW-1:0] ivl;
  logic [TW-1:0] qcnt, dcnt, gap;
  logic [OSW-1:0] os_cnt;
  logic          env_q;

  wire any_cross = pos_cross | neg_cross;
  wire one_cross = pos_cross ^ neg_cross;
  wire alt       = one_cross && (pos_cross != last_pos);

  wire [IW-1:0] ivl_nx  = ivl + IW'(tick);
  wire [TW-1:0] qcnt_nx = qcnt + TW'(tick);
  wire [TW-1:0] dcnt_nx = dcnt + TW'(tick);
  wire [TW-1:0] gap_nx  = any_cross ? '0 : gap + TW'(tick);

  wire [TW-1:0] qual_lim  = (TW'(qual_sel) + TW'(1)) * TW'(DUR_STEP);
  wire [TW-1:0] quiet_lim = (TW'(quiet_sel) + TW'(1)) * TW'(END_STEP);
  wire [TW-1:0] dly_lim   = TW'(dly_sel) * TW'(DLY_STEP);

  wire too_slow = ivl_nx > IW'(ivl_max);
  wire too_fast = alt && (ivl_nx < IW'(ivl_min));
  wire quiet    = gap_nx >= quiet_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      last_pos <= 1'b0;
      ivl      <= '0;
      qcnt     <= '0;
      dcnt     <= '0;
      gap      <= '0;
    end else if (!val_en) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (one_cross) begin
          st       <= S_QUAL;
          last_pos <= pos_cross;
          ivl      <= '0;
          qcnt     <= '0;
          gap      <= '0;
        end
        S_QUAL: begin
          gap <= gap_nx;
          if (too_slow || too_fast) begin
            st <= S_IDLE;
          end else begin
            if (alt) begin
              ivl      <= '0;
              last_pos <= pos_cross;
            end else begin
              ivl <= ivl_nx;
            end
            qcnt <= qcnt_nx;
            if (qcnt_nx >= qual_lim) begin
              dcnt <= '0;
              st   <= (dly_lim == '0) ? S_RING : S_WATCH;
            end
          end
        end
        S_WATCH: begin
          gap  <= gap_nx;
          dcnt <= dcnt_nx;
          if (quiet)                   st <= S_IDLE;
          else if (dcnt_nx >= dly_lim) st <= S_RING;
        end
        default: begin
          gap <= gap_nx;
          if (quiet) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       os_cnt <= '0;
    else if (any_cross)               os_cnt <= OSW'(OS_TICKS);
    else if (tick && os_cnt != '0)    os_cnt <= os_cnt - OSW'(1);
  end

  wire os_on = os_cnt != '0;
  assign env_o = val_en ? (st == S_RING) : os_on;

  wire irq_set = (env_o & ~env_q) | (irq_both & ~env_o & env_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_q      <= 1'b0;
      irq_flag_o <= 1'b0;
    end else begin
      env_q <= env_o;
      if (irq_set)      irq_flag_o <= 1'b1;
      else if (irq_clr) irq_flag_o <= 1'b0;
    end
  end

  assign irq_pin_o  = irq_act_hi ? irq_flag_o : ~irq_flag_o;
  assign rdet_pin_o = rd_raw_sel ? os_on : env_o;

endmodule

// File: rtl/ring_qualifier_chk.sv
module ring_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pos_cross,
  input logic neg_cross,
  input logic val_en,
  input logic irq_act_hi,
  input logic rd_raw_sel,
  input logic irq_clr,
  input logic env_o,
  input logic irq_flag_o,
  input logic irq_pin_o,
  input logic rdet_pin_o
);

  p_rise_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(env_o) |=> irq_flag_o);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && $stable(env_o)) |=> !irq_flag_o);

  p_pin_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(irq_flag_o) && $stable(irq_act_hi)) |-> $stable(irq_pin_o));

  p_raw_when_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_raw_sel && !val_en) |-> (rdet_pin_o == env_o));

  p_oneshot_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_cross || neg_cross) && rd_raw_sel) |=> (rdet_pin_o || !rd_raw_sel));

  p_tick_gate_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (val_en && $past(val_en) && !$past(tick)) |-> $stable(env_o));

endmodule

bind ring_qualifier ring_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pos_cross(pos_cross), .neg_cross(neg_cross),
  .val_en(val_en), .irq_act_hi(irq_act_hi), .rd_raw_sel(rd_raw_sel), .irq_clr(irq_clr),
  .env_o(env_o), .irq_flag_o(irq_flag_o), .irq_pin_o(irq_pin_o), .rdet_pin_o(rdet_pin_o)
);

// File: tb/tb_ring_qualifier.sv
module tb_ring_qualifier;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic pos = 1'b0, neg = 1'b0, val_en = 1'b1;
  logic [5:0] ivl_min = 6'd10, ivl_max = 6'd40;
  logic [2:0] qual_sel = 3'd0, dly_sel = 3'd0;
  logic [3:0] quiet_sel = 4'd3;
  logic irq_both = 1'b0, irq_act_hi = 1'b1, rd_raw_sel = 1'b0, irq_clr = 1'b0;
  logic env, flag, ipin, rdet;

  int checks = 0, fails = 0, tick_div = 1, tphase = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tphase <= tphase + 1;
    tick   <= (tick_div == 1) || (tphase % tick_div == 0);
  end

  ring_qualifier dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pos_cross(pos), .neg_cross(neg),
    .val_en(val_en), .ivl_min(ivl_min), .ivl_max(ivl_max), .qual_sel(qual_sel),
    .dly_sel(dly_sel), .quiet_sel(quiet_sel), .irq_both(irq_both),
    .irq_act_hi(irq_act_hi), .rd_raw_sel(rd_raw_sel), .irq_clr(irq_clr),
    .env_o(env), .irq_flag_o(flag), .irq_pin_o(ipin), .rdet_pin_o(rdet)
  );

  // per, crossings, qual_sel, dly_sel, quiet_sel, sample offset, expected env, requirement
  localparam int VEC [12][8] = '{
    '{32, 3, 0, 0, 3,  50, 1, 7},   // R7 ring active
    '{32, 3, 0, 0, 3, 140, 0, 7},   // R7 quiet timeout ends ring
    '{32, 3, 0, 1, 3, 130, 0, 6},   // R6 tie, quiet wins
    '{32, 3, 0, 1, 4, 130, 1, 6},   // R6 delay first
    '{32, 3, 0, 1, 2, 130, 0, 6},   // R6 quiet first
    '{ 8,12, 0, 0, 3,  20, 0, 3},   // R3 too fast
    '{10, 8, 0, 0, 3,  20, 1, 3},   // R3 exactly minimum
    '{50, 6, 0, 0, 3,  20, 0, 4},   // R4 too slow
    '{40, 3, 0, 0, 3,  20, 1, 4},   // R4 exactly maximum
    '{41, 4, 0, 0, 3,  20, 0, 4},   // R4 one past maximum
    '{32, 3, 1, 0, 3,  50, 0, 5},   // R5 burst shorter than span
    '{32, 5, 1, 0, 3,  20, 1, 5}    // R5 burst long enough
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic xing(input bit p);
    @(negedge clk);
    if (p) pos = 1'b1; else neg = 1'b1;
    @(negedge clk);
    pos = 1'b0; neg = 1'b0;
  endtask

  task automatic burst(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      xing(i % 2 == 0);
      if (i < n - 1) repeat (per - 2) @(negedge clk);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 env", env, 1'b0);
    chk("R1 flag", flag, 1'b0);
    chk("R1 pin", ipin, 1'b0);
    chk("R1 rdet", rdet, 1'b0);

    for (int r = 0; r < 12; r++) begin
      qual_sel  = 3'(VEC[r][2]);
      dly_sel   = 3'(VEC[r][3]);
      quiet_sel = 4'(VEC[r][4]);
      burst(VEC[r][0], VEC[r][1]);
      repeat (VEC[r][5]) @(negedge clk);
      chk($sformatf("R%0d row %0d env", VEC[r][7], r), env, VEC[r][6] != 0);
      repeat (300) @(negedge clk);
      clear_irq();
    end
    qual_sel = 3'd0; dly_sel = 3'd0; quiet_sel = 4'd3;

    // R8 rising edge sets flag, clear strobe clears, falling edge ignored
    burst(32, 3);
    repeat (50) @(negedge clk);
    chk("R8 set on rise", flag, 1'b1);
    chk("R10 pin active high", ipin, 1'b1);
    irq_act_hi = 1'b0;
    @(negedge clk);
    chk("R10 pin active low", ipin, 1'b0);
    irq_act_hi = 1'b1;
    clear_irq();
    chk("R8 cleared", flag, 1'b0);
    repeat (150) @(negedge clk);
    chk("R8 env ended", env, 1'b0);
    chk("R8 fall ignored", flag, 1'b0);

    // R9 both edges
    irq_both = 1'b1;
    burst(32, 3);
    repeat (50) @(negedge clk);
    clear_irq();
    repeat (150) @(negedge clk);
    chk("R9 set on fall", flag, 1'b1);
    irq_both = 1'b0;
    clear_irq();
    repeat (200) @(negedge clk);

    // R2 repeated positive crossing does not shorten the interval
    ivl_min = 6'd20;
    xing(1); repeat (14) @(negedge clk);
    xing(1); repeat (14) @(negedge clk);
    xing(0); repeat (30) @(negedge clk);
    xing(1);
    repeat (20) @(negedge clk);
    chk("R2 same-threshold ignored", env, 1'b1);
    ivl_min = 6'd10;
    repeat (300) @(negedge clk);
    clear_irq();

    // R14 half-rate timebase doubles every window
    tick_div = 2;
    burst(64, 3);
    repeat (200) @(negedge clk);
    chk("R14 ring held on slow tick", env, 1'b1);
    repeat (100) @(negedge clk);
    chk("R14 ring ends on slow tick", env, 1'b0);
    tick_div = 1;
    repeat (300) @(negedge clk);
    clear_irq();

    // R11 / R12 raw one-shot
    repeat (5100) @(negedge clk);
    xing(1);
    repeat (10) @(negedge clk);
    chk("R11 rdet follows envelope", rdet, 1'b0);
    rd_raw_sel = 1'b1;
    @(negedge clk);
    chk("R11 rdet follows one-shot", rdet, 1'b1);
    repeat (4975) @(negedge clk);
    chk("R12 one-shot still high", rdet, 1'b1);
    repeat (40) @(negedge clk);
    chk("R12 one-shot expired", rdet, 1'b0);
    xing(0);
    repeat (2998) @(negedge clk);
    xing(1);
    repeat (3000) @(negedge clk);
    chk("R12 retriggered", rdet, 1'b1);
    repeat (2100) @(negedge clk);
    chk("R12 retrigger expired", rdet, 1'b0);
    rd_raw_sel = 1'b0;
    chk("R7 env idle", env, 1'b0);

    // R13 disabled validation
    val_en = 1'b0;
    xing(0);
    chk("R13 env follows one-shot", env, 1'b1);
    repeat (3) @(negedge clk);
    chk("R13 flag from raw envelope", flag, 1'b1);
    val_en = 1'b1;
    @(negedge clk);
    chk("R13 validator held idle", env, 1'b0);

    finish_run();
  end

endmodule